// File: doc/BRIEF.md
# Bit-Serial Two-Operand Adder

This block adds two operands of a parameterised width, one bit position per clock, starting at the least significant bit. Each operand is held in its own shift register that takes a parallel value on a load strobe and otherwise moves one place toward bit 0 on each enabled clock, with zero fed into the top bit. A small carry state machine combines the two bits at position 0 with the carry it holds and produces one sum bit. A third shift register gathers the sum bits from the top down, so that after the run each bit sits at its own weight.

Control is one pulse. `start_i` loads a down-counter that enables the shift registers for exactly the cycles needed, then raises `done_o`. A parameter selects one of two carry machines. The first has two states, one per carry value, and forms the sum bit combinationally. The second has four states that hold both the carry and the sum bit in flip-flops. That gives a registered sum output, but each bit appears one clock later, so a run takes one extra cycle.

The typical user loads the operands, pulses start, waits for done and reads the sum. The sum stays valid until the next start.

Top module: `bitser_add`

## Requirements
- R1: When `done_o` is high, `sum_o` equals (`opa_i` + `opb_i`) mod 2^WIDTH for the operands of the last load before the start, in both carry variants.
- R2: With the two-state carry machine (REG_SUM=0), `done_o` rises exactly WIDTH clock edges after the edge that samples `start_i`.
- R3: With the four-state carry machine (REG_SUM=1), the sum bit is a flip-flop output whose bit 1 of the state code is the carry and bit 0 is the sum. `done_o` rises exactly WIDTH+1 edges after the start edge.
- R4: A `start_i` pulse while a run is in progress is ignored. Result and completion time are unchanged.
- R5: Every start clears the carry, so the result never depends on the carry left by an earlier run.
- R6: `done_o` is low in the cycle after an accepted start and stays high from completion until the next accepted start.
- R7: While reset is applied and after its release, `sum_o` is 0, `done_o` is 0 and the carry is 0.
- R8: A load takes priority over shifting, and the most recent load before a start decides the operands.
- R9: The carry after an enabled step is the majority of the two operand bits and the previous carry, in both variants.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| load_i | input | 1 | Parallel-load strobe for both operand registers |
| opa_i | input | WIDTH | First operand |
| opb_i | input | WIDTH | Second operand |
| start_i | input | 1 | One-cycle pulse that begins an addition |
| sum_o | output | WIDTH | Collected sum |
| done_o | output | 1 | High once the sum is complete |

## Verification
The hardest conditions to reach from the ports are a stale carry and a repeated start. A stale carry exists only when a run ends with carry 1, so the stimulus adds all-ones to all-ones and then immediately starts a zero-plus-zero run, whose only possible nonzero result would come from that leftover carry. The repeated start is produced by pulsing `start_i` again in the middle of a run and checking both the sum and the exact completion cycle. Both carry variants receive the same stimulus side by side, so any difference in latency or result shows directly.

// File: rtl/bitser_add_pkg.sv
package bitser_add_pkg;
  typedef enum logic {CY_ZERO = 1'b0, CY_ONE = 1'b1} carry2_e;
  // bit 1 = carry, bit 0 = registered sum bit
  typedef enum logic [1:0] {
    C0_S0 = 2'b00,
    C0_S1 = 2'b01,
    C1_S0 = 2'b10,
    C1_S1 = 2'b11
  } carry4_e;
endpackage

// File: rtl/bitser_shreg.sv
module bitser_shreg #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  logic             ld_i,
  input  logic [WIDTH-1:0] ld_val_i,
  input  logic             sh_en_i,
  input  logic             ser_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] q_q, q_d;

  always_comb begin
    q_d = q_q;
    if (ld_i)         q_d = ld_val_i;
    else if (sh_en_i) q_d = {ser_i, q_q[WIDTH-1:1]};
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) q_q <= '0;
    else          q_q <= q_d;
  end

  assign q_o = q_q;

  // R8: load wins over a shift in the same cycle
  p_load_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    ld_i |=> q_o == $past(ld_val_i));

  // R1: a shift moves every bit one place toward bit 0
  p_shift_down_r1: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (!ld_i && sh_en_i) |=> (q_o[WIDTH-2:0] == $past(q_o[WIDTH-1:1])) &&
                           (q_o[WIDTH-1] == $past(ser_i)));
endmodule

// File: rtl/bitser_carry_fsm.sv
module bitser_carry_fsm
  import bitser_add_pkg::*;
#(
  parameter bit REG_SUM = 1'b0
) (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic clr_i,
  input  logic step_i,
  input  logic a_i,
  input  logic b_i,
  output logic sum_o,
  output logic carry_o
);
  generate
    if (REG_SUM) begin : g_four
      carry4_e st_q, st_d;
      logic [1:0] tot;

      always_comb begin
        tot  = {1'b0, a_i} + {1'b0, b_i} + {1'b0, st_q[1]};
        st_d = st_q;
        if (clr_i)       st_d = C0_S0;
        else if (step_i) st_d = carry4_e'(tot);
      end

      always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) st_q <= C0_S0;
        else          st_q <= st_d;
      end

      assign sum_o   = st_q[0];
      assign carry_o = st_q[1];

      // R9: carry 0 with both bits set produces carry 1, sum 0
      p_four_gen_r9: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (step_i && !clr_i && !carry_o && a_i && b_i) |=> st_q == C1_S0);
      // R9: carry 1 with one bit set propagates, sum 0
      p_four_prop_r9: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (step_i && !clr_i && carry_o && (a_i ^ b_i)) |=> st_q == C1_S0);
      // R3: sum bit held while not stepping
      p_four_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (!step_i && !clr_i) |=> $stable(sum_o));
    end else begin : g_two
      carry2_e cy_q, cy_d;

      always_comb begin
        cy_d = cy_q;
        if (clr_i)       cy_d = CY_ZERO;
        else if (step_i) cy_d = carry2_e'((a_i & b_i) | (cy_q & (a_i | b_i)));
      end

      always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) cy_q <= CY_ZERO;
        else          cy_q <= cy_d;
      end

      assign sum_o   = a_i ^ b_i ^ cy_q;
      assign carry_o = cy_q;

      // R9: both bits set always leave carry 1
      p_two_gen_r9: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (step_i && !clr_i && a_i && b_i) |=> carry_o);
      // R9: both bits clear always leave carry 0
      p_two_kill_r9: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (step_i && !clr_i && !a_i && !b_i) |=> !carry_o);
    end
  endgenerate

  // R5: a clear always leaves carry 0
  p_clr_carry_r5: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    clr_i |=> !carry_o);
endmodule

// File: rtl/bitser_seq.sv
module bitser_seq #(
  parameter int WIDTH = 8,
  parameter int LAT   = 0
) (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic start_i,
  output logic go_o,
  output logic op_en_o,
  output logic sum_en_o,
  output logic done_o
);
  localparam int CYC = WIDTH + LAT;
  localparam int CW  = $clog2(CYC + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          done_q, done_d;
  logic          busy;

  assign busy = (cnt_q != '0);
  assign go_o = start_i && !busy;

  always_comb begin
    cnt_d  = cnt_q;
    done_d = done_q;
    if (go_o) begin
      cnt_d  = CW'(CYC);
      done_d = 1'b0;
    end else if (busy) begin
      cnt_d = cnt_q - CW'(1);
      if (cnt_q == CW'(1)) done_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  assign op_en_o  = busy && (cnt_q > CW'(LAT));
  assign sum_en_o = busy && (cnt_q <= CW'(WIDTH));
  assign done_o   = done_q;

  // R4: a start during a run does not reload the counter
  p_start_ignored_r4: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (busy && start_i) |=> cnt_q == $past(cnt_q) - CW'(1));
  // R6: accepted start drops done on the next cycle
  p_go_clears_done_r6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    go_o |=> !done_o);
  // R6: done is never high during a run
  p_done_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    done_o |-> !busy);
  // R6: done holds until a start
  p_done_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (done_o && !start_i) |=> done_o);
endmodule

// File: rtl/bitser_add.sv
module bitser_add #(
  parameter int WIDTH   = 8,
  parameter bit REG_SUM = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  logic             load_i,
  input  logic [WIDTH-1:0] opa_i,
  input  logic [WIDTH-1:0] opb_i,
  input  logic             start_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             done_o
);
  localparam int LAT = REG_SUM ? 1 : 0;

  logic [1:0]       rst_sync_q;
  logic             rst_n;
  logic             go, op_en, sum_en, sbit, carry;
  logic [WIDTH-1:0] a_q, b_q;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) rst_sync_q <= 2'b00;
    else          rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  bitser_seq #(.WIDTH(WIDTH), .LAT(LAT)) u_seq (
    .clk_i    (clk_i),
    .rst_n_i  (rst_n),
    .start_i  (start_i),
    .go_o     (go),
    .op_en_o  (op_en),
    .sum_en_o (sum_en),
    .done_o   (done_o)
  );

  bitser_shreg #(.WIDTH(WIDTH)) u_opa (
    .clk_i(clk_i), .rst_n_i(rst_n), .ld_i(load_i), .ld_val_i(opa_i),
    .sh_en_i(op_en), .ser_i(1'b0), .q_o(a_q)
  );

  bitser_shreg #(.WIDTH(WIDTH)) u_opb (
    .clk_i(clk_i), .rst_n_i(rst_n), .ld_i(load_i), .ld_val_i(opb_i),
    .sh_en_i(op_en), .ser_i(1'b0), .q_o(b_q)
  );

  bitser_carry_fsm #(.REG_SUM(REG_SUM)) u_cy (
    .clk_i   (clk_i),
    .rst_n_i (rst_n),
    .clr_i   (go),
    .step_i  (op_en),
    .a_i     (a_q[0]),
    .b_i     (b_q[0]),
    .sum_o   (sbit),
    .carry_o (carry)
  );

  bitser_shreg #(.WIDTH(WIDTH)) u_sum (
    .clk_i(clk_i), .rst_n_i(rst_n), .ld_i(go), .ld_val_i('0),
    .sh_en_i(sum_en), .ser_i(sbit), .q_o(sum_o)
  );

  // R3: the four-state variant collects one cycle after the operands move
  p_sum_lags_r3: assert property (@(posedge clk_i) disable iff (!rst_n)
    (REG_SUM && op_en && !go) |=> sum_en);
  // R7: no run in progress right after reset release
  p_idle_reset_r7: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(rst_n) |-> !done_o && !carry);
endmodule

// File: tb/bitser_add_tb_top.sv
`timescale 1ns/1ps
module bitser_add_tb_top;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         load = 1'b0;
  logic         start = 1'b0;
  logic [W-1:0] opa = '0, opb = '0;
  logic [W-1:0] sum_t, sum_f;
  logic         done_t, done_f;
  int           n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  bitser_add #(.WIDTH(W), .REG_SUM(1'b0)) dut_i (
    .clk_i(clk), .rst_n_i(rst_n), .load_i(load), .opa_i(opa), .opb_i(opb),
    .start_i(start), .sum_o(sum_t), .done_o(done_t)
  );

  bitser_add #(.WIDTH(W), .REG_SUM(1'b1)) dut_moore_i (
    .clk_i(clk), .rst_n_i(rst_n), .load_i(load), .opa_i(opa), .opb_i(opb),
    .start_i(start), .sum_o(sum_f), .done_o(done_f)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report();
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic do_load(input logic [W-1:0] a, input logic [W-1:0] b);
    @(negedge clk);
    load = 1'b1; opa = a; opb = b;
    @(negedge clk);
    load = 1'b0;
  endtask

  // one addition; poke_k > 0 pulses start again after that many edges
  task automatic run_add(input logic [W-1:0] a, input logic [W-1:0] b,
                         input int poke_k, input string tag);
    logic [W-1:0] exp;
    int kt, kf;
    exp = a + b;
    kt = 0; kf = 0;
    do_load(a, b);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(!done_t && !done_f, {"R6 done low after start ", tag}, {done_t, done_f}, 0);
    for (int k = 1; k <= W + 3; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (done_t && kt == 0) kt = k;
      if (done_f && kf == 0) kf = k;
      start = (poke_k > 0 && k == poke_k);
    end
    start = 1'b0;
    check(kt == W, {"R2 two-state latency ", tag}, kt, W);
    check(kf == W + 1, {"R3 four-state latency ", tag}, kf, W + 1);
    check(sum_t == exp, {"R1 two-state sum ", tag}, sum_t, exp);
    check(sum_f == exp, {"R1 four-state sum ", tag}, sum_f, exp);
    check(done_t && done_f, {"R6 done held ", tag}, {done_t, done_f}, 3);
  endtask

  task automatic t_reset();
    check(sum_t == 0 && sum_f == 0 && !done_t && !done_f, "R7 in reset",
          {sum_t, sum_f}, 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(sum_t == 0 && sum_f == 0 && !done_t && !done_f, "R7 after release",
          {sum_t, sum_f}, 0);
  endtask

  task automatic t_directed();
    run_add(8'h00, 8'h00, 0, "zero");
    run_add(8'hFF, 8'h01, 0, "ripple");
    run_add(8'hAA, 8'h55, 0, "alternate");
    run_add(8'h80, 8'h80, 0, "msb carry out");
  endtask

  task automatic t_stale_carry_r5();
    run_add(8'hFF, 8'hFF, 0, "R5 carry set");
    run_add(8'h00, 8'h00, 0, "R5 carry cleared");
  endtask

  task automatic t_restart_ignored_r4();
    run_add(8'h3C, 8'h47, 3, "R4 mid-run start");
  endtask

  task automatic t_reload_r8();
    do_load(8'h11, 8'h22);
    run_add(8'h9B, 8'h6E, 0, "R8 last load used");
  endtask

  task automatic t_random();
    for (int i = 0; i < 8; i++) begin
      run_add(W'($urandom), W'($urandom), 0, "random");
    end
  endtask

  task automatic t_mid_reset_r7();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(sum_t == 0 && sum_f == 0 && !done_t && !done_f, "R7 reset after run",
          {sum_t, sum_f}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    run_add(8'h01, 8'h00, 0, "R7 carry zero after reset");
  endtask

  initial begin
    void'($urandom(7));
    t_reset();
    t_directed();
    t_stale_carry_r5();
    t_restart_ignored_r4();
    t_reload_r8();
    t_random();
    t_mid_reset_r7();
    report();
  end

  initial begin
    #(20 * 100000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=1 expected=0");
    report();
  end
endmodule